// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This unit watches every instruction fetch and every data access a core makes and compares it against four programmable breakpoint addresses. Each breakpoint carries its own access-type and length setting. A data breakpoint covers a naturally aligned field of one, two or four bytes, and it fires when any byte of the access lands inside that field. An instruction breakpoint fires only on an exact fetch address. When an enabled breakpoint matches, the unit raises a fault request for a fetch hit or a trap request for a data hit. It also records every breakpoint that matched in a sticky status register.

Software reaches the unit through a small indexed register port. Index 0 to 3 are the breakpoint addresses, index 6 is status and index 7 is control. The port can only be used at privilege level zero. A task-switch pulse drops all per-task (local) enables and keeps the global ones. The unit drives the exact-reporting request, but it does not stall anything itself.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset every register reads zero and hit_vec, fetch_fault, data_trap, gp_fault and exact_mode are low.
- R2: Register indices 0 to 3 hold the breakpoint addresses, 6 is status and 7 is control. Indices 4 and 5 read zero and ignore writes. Control keeps only these bits: bit 2n (local enable of breakpoint n), bit 2n+1 (global enable), bit 8 (local exact), bit 9 (global exact), bits 16+4n..17+4n (type of breakpoint n) and bits 18+4n..19+4n (length of breakpoint n). Status keeps only bits 3:0. All other bits read zero.
- R3: A register access (reg_en) while priv_lvl is not zero changes no register, reads zero, and sets gp_fault for one cycle on the next cycle.
- R4: Type code 00 matches instruction fetches only, 01 matches data writes only, and 11 matches data reads and writes. Code 10 never matches. On acc_kind, 00 is a fetch, 01 a read and 10 a write.
- R5: Length code 00 is one byte, 01 is two bytes and 11 is four bytes. The length clears the low 0, 1 or 2 bits of the stored address. Length code 10 never matches.
- R6: A data breakpoint matches when any byte of the access overlaps its field. acc_size uses the same one/two/four-byte codes as the length field, and acc_size 10 never matches.
- R7: An instruction breakpoint matches only a fetch whose address equals the stored address, and only with length 00. An enabled fetch hit raises fetch_fault on the cycle after the access.
- R8: An enabled data hit raises data_trap on the cycle after the access. fetch_fault and data_trap are never high together.
- R9: A debug event happens when a breakpoint whose local or global enable is set matches. On an event, hit_vec and the status bits receive every matching breakpoint, including matching breakpoints whose enables are clear. Without an event hit_vec is zero and status does not change.
- R10: Status bits stay set until software writes them. A write stores the written value, and hit bits from the same cycle are ORed in on top.
- R11: A task_switch pulse clears the four local enables and the local exact bit, and it keeps the global enables and the global exact bit.
- R12: exact_mode is high when either the local or the global exact bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code (00 one, 01 two, 11 four bytes) |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write |
| priv_lvl | input | 2 | Current privilege level |
| task_switch | input | 1 | One-cycle pulse on a task switch |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write when high, read when low |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (same cycle) |
| hit_vec | output | 4 | Breakpoints recorded by the last event |
| fetch_fault | output | 1 | Instruction breakpoint fault request |
| data_trap | output | 1 | Data breakpoint trap request |
| gp_fault | output | 1 | Register access at nonzero privilege |
| exact_mode | output | 1 | Request for exact data-hit reporting |

## Verification
The assertions assume the core presents at most one access per cycle, with a single kind. They also assume that a legal status write, when it happens in the same cycle as an access, is the only thing allowed to drop status bits. The bench drives each access for one cycle and returns acc_valid low before it touches the register port, so accesses and software writes never overlap. The bench also unconfigures breakpoints it is not exercising by setting their type code to 10. This keeps its expected hit vectors free of stray matches.

// File: rtl/bkpt_pkg.sv
// Shared constants for the breakpoint match unit: breakpoint count,
// register indices, field codes and control-register bit masks.
package bkpt_pkg;
    localparam int NUM_BP     = 4;
    localparam int DATA_W     = 32;
    localparam int FIELD_BASE = 16;
    localparam int EXACT_LBIT = 2 * NUM_BP;
    localparam int EXACT_GBIT = 2 * NUM_BP + 1;
    localparam logic [2:0] IDX_STATUS = 3'd6;
    localparam logic [2:0] IDX_CTRL   = 3'd7;

    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] KIND_READ  = 2'b01;
    localparam logic [1:0] KIND_WRITE = 2'b10;

    localparam logic [1:0] TYPE_EXEC  = 2'b00;
    localparam logic [1:0] TYPE_WR    = 2'b01;
    localparam logic [1:0] TYPE_RDWR  = 2'b11;
    localparam logic [1:0] LEN_UNDEF  = 2'b10;

    // All writable control bits.
    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_BP; n++) begin
            m[2*n]                 = 1'b1;
            m[2*n+1]               = 1'b1;
            m[FIELD_BASE+4*n +: 4] = 4'hF;
        end
        m[EXACT_LBIT] = 1'b1;
        m[EXACT_GBIT] = 1'b1;
        return m;
    endfunction

    // Bits dropped by a task switch.
    function automatic logic [DATA_W-1:0] local_mask();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_BP; n++) m[2*n] = 1'b1;
        m[EXACT_LBIT] = 1'b1;
        return m;
    endfunction

    // Bits kept across a task switch.
    function automatic logic [DATA_W-1:0] global_mask();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_BP; n++) m[2*n+1] = 1'b1;
        m[EXACT_GBIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/bkpt_comparator.sv
// One breakpoint comparator. It decides whether the current access matches a
// single breakpoint. Assumes: one access per cycle; fields come straight
// from the control register. Purely combinational.
module bkpt_comparator
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [1:0]        bp_type,
    input  logic [1:0]        bp_len,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    output logic              match
);
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W:0]   f_lo, f_hi, a_lo, a_hi;
    logic [1:0]        span;
    logic              overlap, is_data;

    // Field and access byte ranges, widened by one bit so they cannot wrap.
    always_comb begin
        case (bp_len)
            2'b01:   low_mask = ADDR_W'(1);
            2'b11:   low_mask = ADDR_W'(3);
            default: low_mask = '0;
        endcase
        case (acc_size)
            2'b01:   span = 2'd1;
            2'b11:   span = 2'd3;
            default: span = 2'd0;
        endcase
        f_lo    = {1'b0, bp_addr & ~low_mask};
        f_hi    = f_lo + {1'b0, low_mask};
        a_lo    = {1'b0, acc_addr};
        a_hi    = a_lo + (ADDR_W+1)'(span);
        overlap = (a_lo <= f_hi) && (a_hi >= f_lo)
                  && (bp_len != LEN_UNDEF) && (acc_size != 2'b10);
        is_data = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
    end

    // Match decision selected by the breakpoint's type code.
    always_comb begin
        case (bp_type)
            TYPE_EXEC: match = acc_valid && (acc_kind == KIND_FETCH)
                               && (bp_len == 2'b00) && (acc_addr == bp_addr);
            TYPE_WR:   match = acc_valid && (acc_kind == KIND_WRITE) && overlap;
            TYPE_RDWR: match = acc_valid && is_data && overlap;
            default:   match = 1'b0;
        endcase
    end
endmodule

// File: rtl/bkpt_regs.sv
// Software-visible register file: breakpoint addresses, sticky status and
// control. Assumes: writes are legal only at privilege zero; event bits come
// from the match logic in the same cycle.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_en,
    input  logic                           reg_we,
    input  logic [2:0]                     reg_idx,
    input  logic [DATA_W-1:0]              reg_wdata,
    input  logic [1:0]                     priv_lvl,
    input  logic                           task_switch,
    input  logic [NUM_BP-1:0]              evt_set,
    output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_addr,
    output logic [DATA_W-1:0]              ctrl_q,
    output logic [NUM_BP-1:0]              stat_q,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic                           gp_fault
);
    localparam logic [DATA_W-1:0] CMASK = ctrl_mask();
    localparam logic [DATA_W-1:0] LMASK = local_mask();

    logic              legal, legal_wr;
    logic [DATA_W-1:0] ctrl_nxt;
    logic [NUM_BP-1:0] stat_nxt;

    assign legal    = reg_en && (priv_lvl == 2'd0);
    assign legal_wr = legal && reg_we;

    // Next control and status values: software write, then task switch / hits.
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (legal_wr && reg_idx == IDX_CTRL) ctrl_nxt = reg_wdata & CMASK;
        if (task_switch) ctrl_nxt = ctrl_nxt & ~LMASK;
        stat_nxt = stat_q;
        if (legal_wr && reg_idx == IDX_STATUS) stat_nxt = reg_wdata[NUM_BP-1:0];
        stat_nxt = stat_nxt | evt_set;
    end

    // Control, status and privilege-fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            stat_q   <= '0;
            gp_fault <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_nxt;
            stat_q   <= stat_nxt;
            gp_fault <= reg_en && (priv_lvl != 2'd0);
        end
    end

    // One address register per breakpoint.
    for (genvar n = 0; n < NUM_BP; n++) begin : g_addr
        always_ff @(posedge clk) begin
            if (!rst_n)                              bp_addr[n] <= '0;
            else if (legal_wr && reg_idx == 3'(n))   bp_addr[n] <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Read multiplexer; reserved indices and illegal reads return zero.
    always_comb begin
        reg_rdata = '0;
        if (legal) begin
            for (int n = 0; n < NUM_BP; n++)
                if (reg_idx == 3'(n)) reg_rdata = DATA_W'(bp_addr[n]);
            if (reg_idx == IDX_STATUS) reg_rdata = DATA_W'(stat_q);
            if (reg_idx == IDX_CTRL)   reg_rdata = ctrl_q;
        end
    end
endmodule

// File: rtl/bkpt_match_unit.sv
// Top of the breakpoint match unit. It compares each access against all
// breakpoints, forms the debug event and registers the fault/trap requests.
// Assumes: at most one access per cycle; outputs follow the access by one cycle.
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        priv_lvl,
    input  logic              task_switch,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_BP-1:0] hit_vec,
    output logic              fetch_fault,
    output logic              data_trap,
    output logic              gp_fault,
    output logic              exact_mode
);
    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    logic [DATA_W-1:0]             ctrl_w;
    logic [NUM_BP-1:0]             stat_w;
    logic [NUM_BP-1:0]             match, enabled, evt_set;
    logic                          evt;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .priv_lvl(priv_lvl),
        .task_switch(task_switch), .evt_set(evt_set), .bp_addr(bp_addr),
        .ctrl_q(ctrl_w), .stat_q(stat_w), .reg_rdata(reg_rdata),
        .gp_fault(gp_fault)
    );

    // One comparator per breakpoint, fields sliced from control.
    for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
        bkpt_comparator #(.ADDR_W(ADDR_W)) u_cmp (
            .bp_addr(bp_addr[n]),
            .bp_type(ctrl_w[FIELD_BASE+4*n +: 2]),
            .bp_len(ctrl_w[FIELD_BASE+4*n+2 +: 2]),
            .acc_valid(acc_valid), .acc_addr(acc_addr),
            .acc_size(acc_size), .acc_kind(acc_kind),
            .match(match[n])
        );
        assign enabled[n] = ctrl_w[2*n] | ctrl_w[2*n+1];
    end

    // Event forms when an enabled breakpoint matches; all matches are recorded.
    always_comb begin
        evt     = |(match & enabled);
        evt_set = evt ? match : '0;
    end

    // Registered hit report and fault/trap requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec     <= '0;
            fetch_fault <= 1'b0;
            data_trap   <= 1'b0;
        end else begin
            hit_vec     <= evt_set;
            fetch_fault <= evt && (acc_kind == KIND_FETCH);
            data_trap   <= evt && (acc_kind != KIND_FETCH);
        end
    end

    assign exact_mode = ctrl_w[EXACT_LBIT] | ctrl_w[EXACT_GBIT];
endmodule

// File: rtl/bkpt_match_checker.sv
// Property checker for bkpt_match_unit, attached with bind below.
// Assumes one access per cycle and a synchronous active-low reset.
module bkpt_match_checker
    import bkpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic [1:0]        priv_lvl,
    input logic              task_switch,
    input logic              reg_en,
    input logic              reg_we,
    input logic [2:0]        reg_idx,
    input logic [NUM_BP-1:0] hit_vec,
    input logic              fetch_fault,
    input logic              data_trap,
    input logic              gp_fault,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [NUM_BP-1:0] stat_q
);
    localparam logic [DATA_W-1:0] LMASK = local_mask();
    localparam logic [DATA_W-1:0] GMASK = global_mask();

    logic stat_wr, ctrl_wr;
    assign stat_wr = reg_en && reg_we && reg_idx == IDX_STATUS && priv_lvl == 2'd0;
    assign ctrl_wr = reg_en && reg_we && reg_idx == IDX_CTRL && priv_lvl == 2'd0;

    a_r3_gp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && priv_lvl != 2'd0) |=> gp_fault);
    a_r3_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && priv_lvl != 2'd0 && !task_switch) |=> $stable(ctrl_q));
    a_r7_fault_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_kind == KIND_FETCH) |=> !fetch_fault);
    a_r8_trap_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && (acc_kind == KIND_READ || acc_kind == KIND_WRITE)) |=> !data_trap);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_fault && data_trap));
    a_r9_hits_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~stat_q) == '0);
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));
    a_r11_locals_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> ((ctrl_q & LMASK) == '0));
    a_r11_globals_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !ctrl_wr) |=> ((ctrl_q & GMASK) == ($past(ctrl_q) & GMASK)));
endmodule

bind bkpt_match_unit bkpt_match_checker u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .priv_lvl(priv_lvl), .task_switch(task_switch), .reg_en(reg_en),
    .reg_we(reg_we), .reg_idx(reg_idx), .hit_vec(hit_vec),
    .fetch_fault(fetch_fault), .data_trap(data_trap), .gp_fault(gp_fault),
    .ctrl_q(ctrl_w), .stat_q(stat_w)
);

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = 2'b11;
    logic [1:0]  priv_lvl = '0;
    logic        task_switch = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hit_vec;
    logic        fetch_fault, data_trap, gp_fault, exact_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    bkpt_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .priv_lvl(priv_lvl),
        .task_switch(task_switch), .reg_en(reg_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hit_vec(hit_vec), .fetch_fault(fetch_fault), .data_trap(data_trap),
        .gp_fault(gp_fault), .exact_mode(exact_mode)
    );

    // addr[39:8] size[7:6] kind[5:4] expected hit_vec[3:0]
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {32'h1001, 2'b00, 2'b01, 4'b0001},
        {32'h1002, 2'b00, 2'b10, 4'b0010},
        {32'h1001, 2'b01, 2'b01, 4'b0011},
        {32'h1000, 2'b00, 2'b01, 4'b0000},
        {32'h2002, 2'b01, 2'b10, 4'b0100},
        {32'h2001, 2'b11, 2'b01, 4'b0100},
        {32'h2000, 2'b01, 2'b01, 4'b0000},
        {32'h3001, 2'b01, 2'b01, 4'b1000},
        {32'h3003, 2'b00, 2'b10, 4'b1000},
        {32'h3004, 2'b11, 2'b01, 4'b0000},
        {32'h1003, 2'b11, 2'b01, 4'b0000},
        {32'h3000, 2'b00, 2'b00, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_idx = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_kind = k;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'b11;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            reg_rd(3'(i), rd);
            chk("R1 reg after reset", rd, 32'h0);
        end
        chk("R1 outputs after reset",
            {28'h0, hit_vec}, 32'h0);
        chk("R1 flags after reset",
            {28'h0, fetch_fault, data_trap, gp_fault, exact_mode}, 32'h0);

        // Table configuration: overlap cases (R6, R5)
        reg_wr(3'd0, 32'h1001);
        reg_wr(3'd1, 32'h1002);
        reg_wr(3'd2, 32'h2002);
        reg_wr(3'd3, 32'h3000);
        reg_wr(3'd7, 32'hF733_00AA);
        for (int v = 0; v < NV; v++) begin
            access(VEC[v][39:8], VEC[v][7:6], VEC[v][5:4]);
            chk($sformatf("R6 hit_vec vector %0d", v), {28'h0, hit_vec}, {28'h0, VEC[v][3:0]});
            chk($sformatf("R8 data_trap vector %0d", v), {31'h0, data_trap},
                {31'h0, (|VEC[v][3:0]) && VEC[v][5:4] != 2'b00});
        end
        reg_rd(3'd6, rd);
        chk("R10 status accumulated", rd, 32'hF);

        // R2: reserved bits and indices
        reg_wr(3'd7, 32'hFFFF_FFFF);
        reg_rd(3'd7, rd);
        chk("R2 control reserved bits", rd, 32'hFFFF_03FF);
        reg_wr(3'd5, 32'h1234_5678);
        reg_rd(3'd5, rd);
        chk("R2 reserved index", rd, 32'h0);
        reg_wr(3'd6, 32'hFFFF_FFF0);
        reg_rd(3'd6, rd);
        chk("R10 status cleared by write", rd, 32'h0);

        // R4: type codes
        reg_wr(3'd0, 32'h5000);
        reg_wr(3'd7, 32'h2221_0002);
        access(32'h5000, 2'b00, 2'b01);
        chk("R4 write-only ignores read", {28'h0, hit_vec}, 32'h0);
        access(32'h5000, 2'b00, 2'b10);
        chk("R4 write-only hits write", {28'h0, hit_vec}, 32'h1);
        chk("R8 trap on data hit", {31'h0, data_trap}, 32'h1);
        reg_wr(3'd7, 32'h2222_0002);
        access(32'h5000, 2'b00, 2'b10);
        chk("R4 undefined type never hits", {30'h0, hit_vec[0], data_trap}, 32'h0);

        // R5: length masking and undefined length
        reg_wr(3'd0, 32'h2003);
        reg_wr(3'd7, 32'h2227_0002);
        access(32'h2002, 2'b00, 2'b01);
        chk("R5 two-byte field masked", {28'h0, hit_vec}, 32'h1);
        access(32'h2004, 2'b00, 2'b01);
        chk("R5 outside field", {28'h0, hit_vec}, 32'h0);
        reg_wr(3'd7, 32'h222B_0002);
        access(32'h2003, 2'b00, 2'b01);
        chk("R5 undefined length never hits", {28'h0, hit_vec}, 32'h0);

        // R7: instruction breakpoints
        reg_wr(3'd0, 32'h4000);
        reg_wr(3'd7, 32'h2220_0002);
        access(32'h4000, 2'b00, 2'b00);
        chk("R7 fetch hit fault", {30'h0, fetch_fault, data_trap}, 32'h2);
        chk("R7 fetch hit vector", {28'h0, hit_vec}, 32'h1);
        access(32'h4001, 2'b00, 2'b00);
        chk("R7 fetch other address", {31'h0, fetch_fault}, 32'h0);
        access(32'h4000, 2'b00, 2'b01);
        chk("R7 read ignores exec bp", {30'h0, fetch_fault, data_trap}, 32'h0);
        reg_wr(3'd7, 32'h2224_0002);
        access(32'h4000, 2'b00, 2'b00);
        chk("R7 exec with length 01 no hit", {31'h0, fetch_fault}, 32'h0);

        // R9: disabled matches recorded on an event
        reg_wr(3'd6, 32'h0);
        reg_wr(3'd0, 32'h6000);
        reg_wr(3'd1, 32'h6000);
        reg_wr(3'd7, 32'h2233_0001);
        access(32'h6000, 2'b00, 2'b01);
        chk("R9 disabled match recorded", {28'h0, hit_vec}, 32'h3);
        access(32'h7000, 2'b00, 2'b01);
        chk("R9 no event zero vector", {28'h0, hit_vec}, 32'h0);
        reg_rd(3'd6, rd);
        chk("R10 status sticky", rd, 32'h3);
        reg_wr(3'd6, 32'h0);
        reg_wr(3'd7, 32'h2233_0000);
        access(32'h6000, 2'b00, 2'b01);
        chk("R9 no enable no event", {28'h0, hit_vec, 3'h0, data_trap}, 32'h0);
        reg_rd(3'd6, rd);
        chk("R9 status unchanged without event", rd, 32'h0);

        // R3: privilege protection
        priv_lvl = 2'd3;
        reg_wr(3'd0, 32'hDEAD);
        chk("R3 gp_fault on illegal write", {31'h0, gp_fault}, 32'h1);
        reg_rd(3'd7, rd);
        chk("R3 illegal read returns zero", rd, 32'h0);
        priv_lvl = 2'd0;
        reg_rd(3'd0, rd);
        chk("R3 register unchanged", rd, 32'h6000);
        chk("R3 gp_fault clear on legal access", {31'h0, gp_fault}, 32'h0);

        // R11/R12: task switch and exact mode
        reg_wr(3'd7, 32'h0000_03FF);
        chk("R12 exact mode both bits", {31'h0, exact_mode}, 32'h1);
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        reg_rd(3'd7, rd);
        chk("R11 locals cleared globals kept", rd, 32'h0000_02AA);
        chk("R12 exact mode from global", {31'h0, exact_mode}, 32'h1);
        reg_wr(3'd7, 32'h0000_0100);
        chk("R12 exact mode from local", {31'h0, exact_mode}, 32'h1);
        reg_wr(3'd7, 32'h0);
        chk("R12 exact mode off", {31'h0, exact_mode}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule